// File: doc/BRIEF.md
# Matrix-Ordered Phase Encoder Controller

This controller drives a group of output wires and raises each of them exactly once per communication cycle. The order of the rising edges carries the data: with N wires, any of the N! permutations can be sent. The order is not given as an index or as a sequence. It comes from an N×N precedence matrix in which a set entry at row i, column j means that wire i must rise strictly before wire j. Diagonal entries carry no meaning.

Every matrix entry is qualified by its own valid bit, so the matrix may fill in late and in any order. For each pair of wires the controller applies a small local rule. It fires every wire whose pairwise constraints are all settled and whose predecessors have already risen. It stalls only the wires that belong to a pair whose order is still unknown. Once every wire is high a done flag rises. A clear input then drops all wires and rearms the controller for the next matrix.

Top module: `phase_order_encoder`

## Requirements
- R1: While reset is active, and after its release with no effective matrix entry, all wires are low and done is low.
- R2: Matrix entry (i,j) sits at bit i*N+j of both matrix inputs. It counts as set only when its valid bit and its value bit are both 1; otherwise it counts as clear. The environment never sets both (i,j) and (j,i) at once.
- R3: Wire i may rise on a clock edge only if, for every j≠i, entry (i,j) is set, or entry (j,i) is set and wire j was already high before that edge.
- R4: A wire that meets the R3 condition before a clock edge rises on that same edge, so a fully set total order produces one new wire per clock.
- R5: While neither (i,j) nor (j,i) is set, neither wire i nor wire j rises.
- R6: Wires that are not held back by an unresolved pair keep firing while other pairs remain unresolved.
- R7: A wire that is high stays high, whatever the matrix does, until clear is applied.
- R8: done is high exactly when all N wires are high.
- R9: Clear applied before a clock edge drives all wires low and done low on that edge. While clear is held, no wire rises, even for a fully resolved matrix.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| entryValid | input | N*N | Valid bit of each matrix entry, entry (i,j) at bit i*N+j |
| entryVal | input | N*N | Value bit of each matrix entry, same layout |
| clear | input | 1 | Drops all wires and rearms for the next cycle |
| wires | output | N | Phase-encoded output wires |
| done | output | 1 | All wires high |

## Verification
The bench sends several total orders, including the reverse order and an interleaved one. A design that swaps rows and columns, or that counts the wrong bit, shows a mirrored or scrambled edge order. Two matrices differ only in their valid bits, one of them with conflicting value bits behind cleared valid bits. A design that ignores the valid rail fires wrongly or deadlocks on these. A pair that is left unresolved must stall only its own two wires, a matrix cleared after completion must not drop any wire, and a clear held against a resolved matrix must keep every wire low. A design that fires before its order is known, lets wires fall early, or gives firing priority over clear fails one of these checks.

// File: rtl/phenc_pkg.sv
package phenc_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic clearAll;
    logic fireEn;
  } strobe_t;
endpackage

// File: rtl/phenc_pair_rule.sv
// Local rule for one ordered pair (self, peer): self may go with respect to peer
module phenc_pair_rule (
  input  logic selfFirst,
  input  logic peerFirst,
  input  logic peerFired,
  output logic permit
);
  always_comb permit = selfFirst | (peerFirst & peerFired);
endmodule

// File: rtl/phenc_datapath.sv
module phenc_datapath
  import phenc_pkg::*;
#(
  parameter int N = 4
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [N*N-1:0] entryValid,
  input  logic [N*N-1:0] entryVal,
  input  strobe_t        strobe,
  output logic [N-1:0]   fired
);
  localparam int NN = N * N;

  logic [NN-1:0] effective;
  logic [N-1:0]  permit [N];
  logic [N-1:0]  eligible;

  always_comb effective = entryValid & entryVal;

  for (genvar i = 0; i < N; i++) begin : g_row
    for (genvar j = 0; j < N; j++) begin : g_col
      if (i == j) begin : g_diag
        assign permit[i][j] = 1'b1;
      end else begin : g_pair
        phenc_pair_rule rule_i (
          .selfFirst(effective[i*N+j]),
          .peerFirst(effective[j*N+i]),
          .peerFired(fired[j]),
          .permit   (permit[i][j])
        );
      end
    end
    assign eligible[i] = (&permit[i]) & ~fired[i];
  end

  always_ff @(posedge clk) begin
    if (!rstN)                fired <= '0;
    else if (strobe.clearAll) fired <= '0;
    else if (strobe.fireEn)   fired <= fired | eligible;
  end
endmodule

// File: rtl/phenc_control.sv
module phenc_control
  import phenc_pkg::*;
#(
  parameter int N = 4
) (
  input  logic         clear,
  input  logic [N-1:0] fired,
  output strobe_t      strobe,
  output logic         done
);
  always_comb begin
    done            = &fired;
    strobe.clearAll = clear;
    strobe.fireEn   = !clear && !done;
  end
endmodule

// File: rtl/phase_order_encoder.sv
module phase_order_encoder
  import phenc_pkg::*;
#(
  parameter int N = 4
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [N*N-1:0] entryValid,
  input  logic [N*N-1:0] entryVal,
  input  logic           clear,
  output logic [N-1:0]   wires,
  output logic           done
);
  strobe_t      strobe;
  logic [N-1:0] fired;

  phenc_control #(.N(N)) ctrl_i (
    .clear (clear),
    .fired (fired),
    .strobe(strobe),
    .done  (done)
  );

  phenc_datapath #(.N(N)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .entryValid(entryValid),
    .entryVal  (entryVal),
    .strobe    (strobe),
    .fired     (fired)
  );

  assign wires = fired;
endmodule

// File: rtl/phenc_checker.sv
module phenc_checker #(
  parameter int N = 4
) (
  input logic           clk,
  input logic           rstN,
  input logic [N*N-1:0] entryValid,
  input logic [N*N-1:0] entryVal,
  input logic           clear,
  input logic [N-1:0]   wires,
  input logic           done
);
  logic [N*N-1:0] eff;
  always_comb eff = entryValid & entryVal;

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !clear |=> ((wires & $past(wires)) == $past(wires)));

  // R9
  clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    clear |=> (wires == '0) && !done);

  // R8
  done_chk: assert property (@(posedge clk) disable iff (!rstN)
    done == (&wires));

  for (genvar i = 0; i < N; i++) begin : g_i
    for (genvar j = 0; j < N; j++) begin : g_j
      if (i != j) begin : g_p
        // R2
        conflict_chk: assert property (@(posedge clk) disable iff (!rstN)
          !(eff[i*N+j] && eff[j*N+i]));
        // R3
        order_chk: assert property (@(posedge clk) disable iff (!rstN)
          ($rose(wires[j]) && $past(eff[i*N+j])) |-> $past(wires[i]));
        // R5
        unresolved_chk: assert property (@(posedge clk) disable iff (!rstN)
          $rose(wires[i]) |-> $past(eff[i*N+j] || eff[j*N+i]));
      end
    end
  end
endmodule

bind phase_order_encoder phenc_checker #(.N(N)) chk_i (.*);

// File: tb/phase_order_encoder_tb_top.sv
`timescale 1ns/1ps
module phase_order_encoder_tb_top;
  localparam int N  = 4;
  localparam int NV = 5;
  // {valid[47:32], value[31:16], expected wires after edge 4..1 as nibbles}
  localparam logic [47:0] VEC [NV] = '{
    {16'hFFFF, 16'h08CE, 16'hF731},  // order 0,1,2,3
    {16'hFFFF, 16'h7310, 16'hFEC8},  // order 3,2,1,0
    {16'hFFFF, 16'h2B0A, 16'hFD54},  // order 2,0,3,1
    {16'h08CE, 16'h08CE, 16'hF731},  // zeros only via cleared valid
    {16'h7310, 16'hFFFF, 16'hFEC8}   // conflicting values masked by valid
  };

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic [N*N-1:0] entryValid = '0;
  logic [N*N-1:0] entryVal = '0;
  logic           clear = 1'b0;
  logic [N-1:0]   wires;
  logic           done;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  phase_order_encoder #(.N(N)) dut_i (
    .clk(clk), .rstN(rstN), .entryValid(entryValid), .entryVal(entryVal),
    .clear(clear), .wires(wires), .done(done)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    step(); step();
    chk("R1 wires in reset", 32'(wires), 0);
    chk("R1 done in reset", 32'(done), 0);
    rstN = 1'b1;
    step();
    chk("R1 wires after reset", 32'(wires), 0);
    chk("R1 done after reset", 32'(done), 0);

    for (int v = 0; v < NV; v++) begin
      clear = 1'b1;
      step();
      chk("R9 clear between vectors", 32'(wires), 0);
      entryValid = VEC[v][47:32];
      entryVal   = VEC[v][31:16];
      clear      = 1'b0;
      for (int k = 0; k < 4; k++) begin
        step();
        if (v < 3) chk("R3 R4 order", 32'(wires), 32'(VEC[v][4*k +: 4]));
        else       chk("R2 valid gating", 32'(wires), 32'(VEC[v][4*k +: 4]));
        chk("R8 done", 32'(done), (k == 3) ? 1 : 0);
      end
    end

    // Pair (2,3) unresolved: value set but valid cleared
    clear = 1'b1;
    step();
    chk("R9 clear", 32'(wires), 0);
    entryValid = 16'hF7FF;
    entryVal   = 16'h08CE;
    clear      = 1'b0;
    step(); chk("R6 partial progress", 32'(wires), 32'h1);
    step(); chk("R6 partial progress", 32'(wires), 32'h3);
    step(); chk("R5 stall unresolved", 32'(wires), 32'h3);
    step(); chk("R5 stall unresolved", 32'(wires), 32'h3);
    chk("R8 done low while stalled", 32'(done), 0);
    entryValid = 16'hFFFF;
    step(); chk("R3 late resolution", 32'(wires), 32'h7);
    step(); chk("R3 late resolution", 32'(wires), 32'hF);
    chk("R8 done after completion", 32'(done), 1);

    // Matrix withdrawn after completion
    entryValid = '0;
    entryVal   = '0;
    for (int k = 0; k < 3; k++) begin
      step();
      chk("R7 hold wires", 32'(wires), 32'hF);
      chk("R7 hold done", 32'(done), 1);
    end

    // Clear held against a resolved matrix
    entryValid = 16'hFFFF;
    entryVal   = 16'h08CE;
    clear      = 1'b1;
    for (int k = 0; k < 3; k++) begin
      step();
      chk("R9 clear priority wires", 32'(wires), 0);
      chk("R9 clear priority done", 32'(done), 0);
    end
    clear = 1'b0;
    step(); chk("R4 rearmed", 32'(wires), 32'h1);

    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end
endmodule